// File: doc/BRIEF.md
# Two-Wire Output-Enable Register Slave

This block is a write-only slave on a two-wire serial bus (SMBus-style block write). It keeps the enable state of ten differential clock output pairs. A write transfer opens with an address byte, then a command byte and a byte-count byte, then the data bytes. The first two data bytes are stored in a low and a high control register. The enable vector is decoded from those registers and drives the three-state control of each output pair.

Both bus lines are sampled by a faster system clock. Each line passes through a two-flop synchroniser, and edges are found on the synchronised copies. The bidirectional data line is split into an input and an open-drain pull-low enable, which the slave asserts only to acknowledge. Control is a small state machine with four states: `S_IDLE` (waiting for START), `S_RX` (shifting in eight bits), `S_ACK` (holding the data line low through the ninth clock) and `S_SKIP` (an address that is not ours, silent until the next START or STOP). A phase register (`PH_ADDR`, `PH_CMD`, `PH_CNT`, `PH_DATA0`, `PH_DATA1`, `PH_EXTRA`) records which byte of the transfer is arriving.

The transitions are:
- Any state goes to `S_RX`/`PH_ADDR` on START.
- Any state goes to `S_IDLE` on STOP.
- `S_RX` goes to `S_ACK` on the falling clock after eight bits, unless the phase is `PH_ADDR` and the address misses, in which case it goes to `S_SKIP`.
- `S_ACK` goes back to `S_RX` with the next phase on the ninth falling clock.

Top module: `oe_ctrl_slave`

## Requirements
- R1: After reset `pair_en` is 10'h3FF, the reserved high-register bits hold 0, and `sda_pull` is low.
- R2: The address byte carries the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write). On a match with bit 0 = 0, the slave pulls the data line low during the ninth clock. It does the same for every later byte of that transfer.
- R3: When the address differs, or bit 0 is 1, the slave does not acknowledge that byte or any later byte until the next START, and `pair_en` does not change.
- R4: The fourth byte after START (first data byte) loads the low register. Its bit 7-i enables pair i for i = 0..7, where 1 drives the pair and 0 three-states it. Any change on `pair_en` appears in the same cycle that the acknowledge pull begins.
- R5: The fifth byte (second data byte) loads the high register: bit 7 enables pair 8 and bit 6 enables pair 9. Bits 5:0 are stored as written and have no effect on `pair_en`.
- R6: The command byte (second byte) and the count byte (third byte) are acknowledged and leave `pair_en` unchanged.
- R7: Data bytes after the second are acknowledged and discarded.
- R8: A START (data falls while the clock is high) at any point restarts the address phase. Registers written earlier keep their values.
- R9: A STOP (data rises while the clock is high) at any point ends the transfer. A partly received byte is not written, and the pull is released.
- R10: `sda_pull` changes only while the synchronised serial clock is low, and it is never asserted while a data bit is being clocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level (idle high) |
| sda_in | input | 1 | Serial data line level (idle high) |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| pair_en | output | 10 | Per-pair enable, 1 = drive, 0 = three-state |

## Verification
A wrong sequencing state shows up at the ports within one byte. A skipped or extra phase moves the data into the wrong register, and `pair_en` is then wrong right after that byte's acknowledge. A missed address decode shows as a missing or unexpected data-line pull in the ninth clock of the address byte. An abort that is not handled leaves the next transfer acknowledged at the wrong byte, or lets a partial byte reach the enables, so it appears on the first byte after the START or STOP. Random transfers mix address misses, read-direction bits, extra data bytes and aborts in the middle of a byte. They are checked against a bench model of the two registers.

// File: rtl/oe_pkg.sv
package oe_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_SKIP
    } bus_state_t;

    typedef enum logic [2:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA0,
        PH_DATA1,
        PH_EXTRA
    } phase_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            last  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~last;
    assign fall = ~q & last;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
    import oe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda_bit,
    input  logic                 start_det,
    input  logic                 stop_det,
    output logic                 sda_pull,
    output logic                 wr_en,
    output logic                 wr_hi,
    output logic [BYTE_BITS-1:0] wr_data
);
    localparam int               CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_BITS);

    bus_state_t           state, state_n;
    phase_t               phase, phase_n;
    logic [CNT_W-1:0]     bit_cnt, cnt_n;
    logic [BYTE_BITS-1:0] shreg, sh_n;
    logic                 addr_hit;
    logic                 byte_end;

    function automatic phase_t step_phase(input phase_t p);
        unique case (p)
            PH_ADDR:  return PH_CMD;
            PH_CMD:   return PH_CNT;
            PH_CNT:   return PH_DATA0;
            PH_DATA0: return PH_DATA1;
            default:  return PH_EXTRA;
        endcase
    endfunction

    assign addr_hit = (shreg == {DEV_ADDR, 1'b0});
    assign byte_end = (state == S_RX) && scl_fall && (bit_cnt == FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state   <= state_n;
            phase   <= phase_n;
            bit_cnt <= cnt_n;
            shreg   <= sh_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        phase_n = phase;
        cnt_n   = bit_cnt;
        sh_n    = shreg;
        if (start_det) begin
            state_n = S_RX;
            phase_n = PH_ADDR;
            cnt_n   = '0;
        end else if (stop_det) begin
            state_n = S_IDLE;
            phase_n = PH_ADDR;
            cnt_n   = '0;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_SKIP: ;
                S_RX: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        sh_n  = {shreg[BYTE_BITS-2:0], sda_bit};
                        cnt_n = bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        if (phase == PH_ADDR && !addr_hit)
                            state_n = S_SKIP;
                        else
                            state_n = S_ACK;
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        state_n = S_RX;
                        cnt_n   = '0;
                        phase_n = step_phase(phase);
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = (state == S_ACK);
        wr_en    = byte_end && !start_det && !stop_det &&
                   (phase == PH_DATA0 || phase == PH_DATA1);
        wr_hi    = (phase == PH_DATA1);
        wr_data  = shreg;
    end

    assert_ack_after_full_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK && $past(state) != S_ACK) |-> ($past(bit_cnt) == FULL));

    assert_skip_leaves_on_condition_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_SKIP && state != S_SKIP) |-> $past(start_det || stop_det));

    assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_RX && phase == PH_ADDR && bit_cnt == '0));

    assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE && !sda_pull));
endmodule

// File: rtl/oe_regfile.sv
module oe_regfile
    import oe_pkg::*;
#(
    parameter int NUM_PAIRS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic [BYTE_BITS-1:0] wr_data,
    output logic [NUM_PAIRS-1:0] pair_en
);
    localparam int NUM_REGS = 2;

    function automatic logic [BYTE_BITS-1:0] pwr_val(input int r);
        logic [BYTE_BITS-1:0] v;
        v = '0;
        for (int b = 0; b < BYTE_BITS; b++)
            if (r * BYTE_BITS + b < NUM_PAIRS) v[BYTE_BITS-1-b] = 1'b1;
        return v;
    endfunction

    logic [BYTE_BITS-1:0] regs [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[r] <= pwr_val(r);
                else if (wr_en && (wr_hi == (r == 1)))
                    regs[r] <= wr_data;
            end
        end
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_map
            assign pair_en[i] = regs[i / BYTE_BITS][BYTE_BITS-1-(i % BYTE_BITS)];
        end
    endgenerate

    assert_pwr_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pair_en == {NUM_PAIRS{1'b1}} && regs[1] == pwr_val(1)));

    assert_high_stored_as_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (regs[1] == $past(wr_data)));
endmodule

// File: rtl/oe_ctrl_slave.sv
module oe_ctrl_slave
    import oe_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_PAIRS   = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_pull,
    output logic [NUM_PAIRS-1:0] pair_en
);
    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_det, stop_det;
    logic wr_en, wr_hi;
    logic [BYTE_BITS-1:0] wr_data;

    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_in),
        .q(scl_s), .rise(scl_rise), .fall(scl_fall)
    );

    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_in),
        .q(sda_s), .rise(sda_rise), .fall(sda_fall)
    );

    assign start_det = scl_s & sda_fall;
    assign stop_det  = scl_s & sda_rise;

    bus_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_bit(sda_s),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data)
    );

    oe_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .pair_en(pair_en)
    );

    assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    assert_en_moves_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en != $past(pair_en)) |-> (sda_pull && !$past(sda_pull)));
endmodule

// File: tb/oe_ctrl_slave_test.sv
module oe_ctrl_slave_test;
    localparam logic [6:0] DEV = 7'h69;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic [9:0] pair_en;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] r0 = 8'hFF;
    logic [7:0] r1 = 8'hC0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    oe_ctrl_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .pair_en(pair_en)
    );

    function automatic logic [9:0] exp_en(input logic [7:0] lo, input logic [7:0] hi);
        logic [9:0] e;
        for (int i = 0; i < 8; i++) e[i] = lo[7-i];
        e[8] = hi[7];
        e[9] = hi[6];
        return e;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(HP);
            m_scl = 1'b1; tick(HP/2);
            chk(sda_pull == 1'b0, "R10 pull during data bit", 16'(sda_pull), 16'h0);
            tick(HP/2);
            m_scl = 1'b0; tick(HP);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP/2);
        acked = !sda_line;
        tick(HP/2);
        m_scl = 1'b0; tick(HP);
    endtask

    task automatic check_en(input string req);
        chk(pair_en == exp_en(r0, r1), req, 16'(pair_en), 16'(exp_en(r0, r1)));
    endtask

    // matched header: address, command, count
    task automatic header(input logic [7:0] cmd, input logic [7:0] cnt);
        bit a;
        send_byte({DEV, 1'b0}, a);
        chk(a, "R2 address ack", 16'(a), 16'h1);
        send_byte(cmd, a);
        chk(a, "R2 R6 command ack", 16'(a), 16'h1);
        send_byte(cnt, a);
        chk(a, "R2 R6 count ack", 16'(a), 16'h1);
        check_en("R6 header leaves enables");
    endtask

    task automatic data_byte(input int k, input logic [7:0] d);
        bit a;
        send_byte(d, a);
        chk(a, "R2 R7 data ack", 16'(a), 16'h1);
        if (k == 0) r0 = d;
        else if (k == 1) r1 = d;
        check_en(k == 0 ? "R4 low register" : (k == 1 ? "R5 high register" : "R7 extra byte discarded"));
    endtask

    task automatic random_txn();
        bit a;
        bit addr_ok, rd;
        int nd;
        addr_ok = ($urandom % 4) != 0;
        rd = ($urandom % 5) == 0;
        bus_start();
        if (!addr_ok || rd) begin
            send_byte({addr_ok ? DEV : (DEV ^ 7'h15), rd}, a);
            chk(!a, "R3 foreign address no ack", 16'(a), 16'h0);
            send_byte(8'($urandom), a);
            chk(!a, "R3 later byte no ack", 16'(a), 16'h0);
            bus_stop();
            check_en("R3 enables unchanged");
            return;
        end
        header(8'($urandom), 8'($urandom));
        nd = $urandom % 4;
        for (int k = 0; k < nd; k++) data_byte(k, 8'($urandom));
        if (($urandom % 5) == 0) begin
            send_bits(8'($urandom), 1 + ($urandom % 6));
            if ($urandom % 2) begin
                bus_stop();
                check_en("R9 partial byte dropped");
                chk(sda_pull == 1'b0, "R9 pull released", 16'(sda_pull), 16'h0);
                return;
            end
            bus_start();
            header(8'($urandom), 8'($urandom));
            check_en("R8 restart keeps registers");
            data_byte(0, 8'($urandom));
        end
        bus_stop();
        check_en("R9 after stop");
    endtask

    initial begin
        bit a;
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk(pair_en == 10'h3FF, "R1 reset enables", 16'(pair_en), 16'h3FF);
        chk(sda_pull == 1'b0, "R1 reset pull", 16'(sda_pull), 16'h0);

        // full write with an extra data byte, reserved bits set
        bus_start();
        header(8'h00, 8'h02);
        data_byte(0, 8'h5A);
        data_byte(1, 8'h3F);
        chk(pair_en[9:8] == 2'b00, "R5 reserved bits no effect", 16'(pair_en[9:8]), 16'h0);
        data_byte(2, 8'hFF);
        bus_stop();
        check_en("R7 after stop");

        // all enables off, then all on
        bus_start();
        header(8'h11, 8'h02);
        data_byte(0, 8'h00);
        data_byte(1, 8'h00);
        bus_stop();
        chk(pair_en == 10'h000, "R4 R5 all pairs three-stated", 16'(pair_en), 16'h0);

        // wrong address and read direction
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a);
        chk(!a, "R3 wrong address", 16'(a), 16'h0);
        send_byte(8'hFF, a);
        chk(!a, "R3 no ack after miss", 16'(a), 16'h0);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk(!a, "R3 read direction", 16'(a), 16'h0);
        bus_stop();
        check_en("R3 unchanged");

        // STOP inside the first data byte
        bus_start();
        header(8'h00, 8'h02);
        send_bits(8'hFF, 5);
        bus_stop();
        check_en("R9 mid-byte stop");
        chk(sda_pull == 1'b0, "R9 pull idle", 16'(sda_pull), 16'h0);

        // repeated START inside a data byte and inside the address
        bus_start();
        header(8'h00, 8'h02);
        data_byte(0, 8'hF0);
        send_bits(8'h00, 3);
        bus_start();
        send_bits({DEV, 1'b0}, 4);
        bus_start();
        header(8'h00, 8'h02);
        check_en("R8 registers kept");
        data_byte(0, 8'h0F);
        bus_stop();

        for (int t = 0; t < 40; t++) random_txn();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule